// File: doc/BRIEF.md
# Flash Busy, Suspend and Power-State Sequencer

This block sits behind the command decoder of a serial flash back-end and owns the time-related state of the device. It starts a self-timed program or erase and holds the ready/busy flag until a cycle counter runs out. It records whether any byte of the finished operation failed. Program and erase work can be paused and restarted. The block remembers which sector holds a paused erase and rejects commands that would conflict with it. It also carries out a guarded software reset and moves the device into and out of a low-power sleep state.

The front-end presents one decoded command per strobe, at the moment chip select rises. With it come a flag that says the command arrived complete and ended on a byte boundary, a flag for a correct confirmation byte, and a target sector. The block answers one cycle later with an accept or abort pulse, plus a pulse asking the front-end to clear its write-enable latch. Operation lengths are parameter counts of clock cycles, not real flash timing.

Top module: `flash_busy_ctl`

## Requirements
- R1: After reset, busy, error, both pause flags and the sleep flag are all 0.
- R2: Command codes are 1 program, 2 small erase, 3 medium erase, 4 large erase. A complete one that is accepted gives an accept pulse in the cycle after the strobe. Busy is then high for exactly PROG_CYC, ER_S_CYC, ER_M_CYC or ER_L_CYC cycles (defaults 20/40/60/80). A write-enable-clear pulse comes in the first cycle that busy is low. A program or erase that arrives while busy is ignored.
- R3: A program or erase that is not complete on a byte boundary gives an abort pulse and does not start.
- R4: A pause (code 5) while busy drops busy in the next cycle. It sets the program-paused or erase-paused flag, according to the running kind. The busy cycles before the pause and after the restart add up to the full length.
- R5: Restart (code 6) while not busy resumes a paused program before a paused erase. A program may be paused inside a paused erase, and each level then runs to completion.
- R6: A program aimed at the sector of a paused erase aborts with a write-enable-clear pulse. A program to any other sector runs.
- R7: While any pause is outstanding, an erase or a second program aborts with a write-enable-clear pulse.
- R8: If the fail input is high during an active operation, the error flag reads 1 after that operation ends. A new program or erase clears it at its start.
- R9: Software reset (code 7) takes effect only when the enable input, the confirmation flag and the complete flag are all 1. It then abandons running and paused work and clears error. In any other case it has no effect.
- R10: Sleep entry (code 8) is ignored while busy. When not busy and complete, it sets the sleep flag. When incomplete, it aborts.
- R11: While asleep, every command except wake is ignored, including a valid reset.
- R12: Wake (code 9) when incomplete aborts, and the device stays asleep. When complete, it clears the sleep flag with an accept pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 4 | Command code (see R2, R4, R5, R9-R12) |
| cmd_whole | input | 1 | Command complete and ended on a byte boundary |
| cmd_confirm | input | 1 | Confirmation byte was correct |
| cmd_sector | input | SEC_W | Target sector |
| rst_enable | input | 1 | Software reset permitted |
| op_fail | input | 1 | Array reports a failed byte this cycle |
| busy | output | 1 | Self-timed operation in progress |
| err_flag | output | 1 | Last completed operation had a failure |
| prog_paused | output | 1 | A program is paused |
| erase_paused | output | 1 | An erase is paused |
| asleep | output | 1 | Deep power-down state |
| cmd_accept | output | 1 | Command took effect (one cycle) |
| cmd_abort | output | 1 | Command was refused (one cycle) |
| wel_clear | output | 1 | Request to clear write-enable latch (one cycle) |

## Verification
The hardest state to reach is the nested pause: an erase is paused, a program runs in another sector, and that program is paused too. A restart must then pick the program, and the erase must wait for the next restart. The bench reaches it with a fixed sequence: start an erase, pause it, start a program in a different sector, pause that, then restart twice. It counts busy cycles at each step so the lengths must add up exactly. From the same paused-erase state it tries a program in the paused sector, a fresh erase, and a reset without its enable or confirmation. None of these may disturb the pause flags.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam logic [3:0] OP_PROG   = 4'd1;
  localparam logic [3:0] OP_ER_S   = 4'd2;
  localparam logic [3:0] OP_ER_M   = 4'd3;
  localparam logic [3:0] OP_ER_L   = 4'd4;
  localparam logic [3:0] OP_PAUSE  = 4'd5;
  localparam logic [3:0] OP_RESUME = 4'd6;
  localparam logic [3:0] OP_SWRST  = 4'd7;
  localparam logic [3:0] OP_SLEEP  = 4'd8;
  localparam logic [3:0] OP_WAKE   = 4'd9;

  typedef enum logic [1:0] {K_IDLE = 2'd0, K_PROG = 2'd1, K_ERASE = 2'd2} kind_e;

  function automatic logic is_erase(input logic [3:0] op);
    return (op == OP_ER_S) || (op == OP_ER_M) || (op == OP_ER_L);
  endfunction
endpackage

// File: rtl/fbc_op_timer.sv
module fbc_op_timer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          stop,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          done
);
  assign done = busy && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (stop) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end else if (busy) begin
      if (cnt == CW'(1)) busy <= 1'b0;
      cnt <= cnt - CW'(1);
    end
  end

  // R2: the last counted cycle ends the busy period
  p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load && !stop) |=> !busy);
  // R4: a stop always leaves the timer idle
  p_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy);
endmodule

// File: rtl/fbc_susp_store.sv
module fbc_susp_store #(
  parameter int CW    = 7,
  parameter int SEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_p,
  input  logic             save_e,
  input  logic             take_p,
  input  logic             take_e,
  input  logic             clear_all,
  input  logic [CW-1:0]    rem_in,
  input  logic [SEC_W-1:0] sec_in,
  output logic             p_held,
  output logic             e_held,
  output logic [CW-1:0]    p_rem,
  output logic [CW-1:0]    e_rem,
  output logic [SEC_W-1:0] e_sec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_held <= 1'b0;
      e_held <= 1'b0;
      p_rem  <= '0;
      e_rem  <= '0;
      e_sec  <= '0;
    end else if (clear_all) begin
      p_held <= 1'b0;
      e_held <= 1'b0;
    end else begin
      if (save_p) begin
        p_held <= 1'b1;
        p_rem  <= rem_in;
      end else if (take_p) begin
        p_held <= 1'b0;
      end
      if (save_e) begin
        e_held <= 1'b1;
        e_rem  <= rem_in;
        e_sec  <= sec_in;
      end else if (take_e) begin
        e_held <= 1'b0;
      end
    end
  end

  // R5: only one pause of each kind may be outstanding
  p_single_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    save_p |-> !p_held);
  p_single_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    save_e |-> !e_held);
  // R5: an erase resumes only after the program pause is gone
  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_e |-> !p_held);
endmodule

// File: rtl/fbc_pd_ctl.sv
module fbc_pd_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  input  logic busy_i,
  output logic asleep
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     asleep <= 1'b0;
    else if (enter) asleep <= 1'b1;
    else if (leave) asleep <= 1'b0;
  end

  // R10: sleep is never entered during a timed operation
  p_no_sleep_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    enter |-> !busy_i);
  // R10: sleeping and busy never coexist
  p_sleep_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !busy_i);
endmodule

// File: rtl/flash_busy_ctl.sv
module flash_busy_ctl
  import fbc_pkg::*;
#(
  parameter int SEC_W    = 5,
  parameter int PROG_CYC = 20,
  parameter int ER_S_CYC = 40,
  parameter int ER_M_CYC = 60,
  parameter int ER_L_CYC = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic             cmd_whole,
  input  logic             cmd_confirm,
  input  logic [SEC_W-1:0] cmd_sector,
  input  logic             rst_enable,
  input  logic             op_fail,
  output logic             busy,
  output logic             err_flag,
  output logic             prog_paused,
  output logic             erase_paused,
  output logic             asleep,
  output logic             cmd_accept,
  output logic             cmd_abort,
  output logic             wel_clear
);
  localparam int MAXC = (PROG_CYC > ER_L_CYC) ? PROG_CYC : ER_L_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  function automatic logic [CW-1:0] dur_of(input logic [3:0] op);
    case (op)
      OP_PROG: return CW'(PROG_CYC);
      OP_ER_S: return CW'(ER_S_CYC);
      OP_ER_M: return CW'(ER_M_CYC);
      default: return CW'(ER_L_CYC);
    endcase
  endfunction

  kind_e            kind;
  logic [SEC_W-1:0] op_sec;
  logic             p_fail, e_fail;

  logic             t_load, t_stop, t_done;
  logic [CW-1:0]    t_val, t_cnt;
  logic             save_p, save_e, take_p, take_e, wipe;
  logic [CW-1:0]    p_rem, e_rem;
  logic [SEC_W-1:0] e_sec;
  logic             pd_enter, pd_leave;
  logic             start_p, start_e, finish;
  logic             acc_n, abt_n, welc_n;

  fbc_op_timer #(.CW(CW)) u_timer (
    .clk, .rst_n, .load(t_load), .load_val(t_val), .stop(t_stop),
    .busy, .cnt(t_cnt), .done(t_done)
  );

  fbc_susp_store #(.CW(CW), .SEC_W(SEC_W)) u_susp (
    .clk, .rst_n, .save_p, .save_e, .take_p, .take_e, .clear_all(wipe),
    .rem_in(t_cnt - CW'(1)), .sec_in(op_sec),
    .p_held(prog_paused), .e_held(erase_paused),
    .p_rem, .e_rem, .e_sec
  );

  fbc_pd_ctl u_pd (
    .clk, .rst_n, .enter(pd_enter), .leave(pd_leave), .busy_i(busy), .asleep
  );

  always_comb begin
    t_load = 1'b0; t_val = '0; t_stop = 1'b0;
    save_p = 1'b0; save_e = 1'b0; take_p = 1'b0; take_e = 1'b0; wipe = 1'b0;
    pd_enter = 1'b0; pd_leave = 1'b0;
    start_p = 1'b0; start_e = 1'b0;
    acc_n = 1'b0; abt_n = 1'b0; welc_n = 1'b0;
    if (cmd_valid) begin
      if (asleep) begin
        if (cmd_op == OP_WAKE) begin
          if (cmd_whole) begin pd_leave = 1'b1; acc_n = 1'b1; end
          else abt_n = 1'b1;
        end
      end else if (cmd_op == OP_PROG || is_erase(cmd_op)) begin
        if (!busy) begin
          if (prog_paused || (erase_paused &&
              (is_erase(cmd_op) || cmd_sector == e_sec))) begin
            abt_n = 1'b1; welc_n = 1'b1;
          end else if (!cmd_whole) begin
            abt_n = 1'b1;
          end else begin
            t_load = 1'b1; t_val = dur_of(cmd_op); acc_n = 1'b1;
            start_p = (cmd_op == OP_PROG);
            start_e = !start_p;
          end
        end
      end else begin
        case (cmd_op)
          OP_PAUSE: if (busy && !t_done) begin
            t_stop = 1'b1; acc_n = 1'b1;
            save_p = (kind == K_PROG);
            save_e = (kind == K_ERASE);
          end
          OP_RESUME: if (!busy) begin
            if (prog_paused) begin
              take_p = 1'b1; t_load = 1'b1; t_val = p_rem; acc_n = 1'b1;
            end else if (erase_paused) begin
              take_e = 1'b1; t_load = 1'b1; t_val = e_rem; acc_n = 1'b1;
            end
          end
          OP_SWRST: if (rst_enable && cmd_confirm && cmd_whole) begin
            t_stop = 1'b1; wipe = 1'b1; acc_n = 1'b1;
          end
          OP_SLEEP: if (!busy) begin
            if (cmd_whole) begin pd_enter = 1'b1; acc_n = 1'b1; end
            else abt_n = 1'b1;
          end
          default: ;
        endcase
      end
    end
    finish = t_done && !t_stop;
    if (finish) welc_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= K_IDLE; op_sec <= '0; p_fail <= 1'b0; e_fail <= 1'b0;
      err_flag <= 1'b0; cmd_accept <= 1'b0; cmd_abort <= 1'b0; wel_clear <= 1'b0;
    end else begin
      cmd_accept <= acc_n;
      cmd_abort  <= abt_n;
      wel_clear  <= welc_n;
      if (kind == K_PROG  && busy && op_fail) p_fail <= 1'b1;
      if (kind == K_ERASE && busy && op_fail) e_fail <= 1'b1;
      if (wipe) begin
        kind <= K_IDLE; err_flag <= 1'b0;
      end else if (start_p || take_p) begin
        kind <= K_PROG;
        if (start_p) begin p_fail <= 1'b0; err_flag <= 1'b0; op_sec <= cmd_sector; end
      end else if (start_e || take_e) begin
        kind <= K_ERASE;
        if (start_e) begin e_fail <= 1'b0; err_flag <= 1'b0; op_sec <= cmd_sector; end
        else op_sec <= e_sec;
      end else if (finish || t_stop) begin
        kind <= K_IDLE;
        if (finish)
          err_flag <= (kind == K_PROG) ? (p_fail || op_fail) : (e_fail || op_fail);
      end
    end
  end

  // R6: program into the paused erase sector is refused
  p_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !asleep && !busy && cmd_op == OP_PROG && erase_paused &&
     cmd_sector == e_sec) |=> (cmd_abort && wel_clear && !busy));
  // R11: asleep, non-wake commands change nothing
  p_sleep_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && asleep && cmd_op != OP_WAKE) |=> (asleep && !cmd_accept && !busy));
  // R12: incomplete wake keeps the sleep state
  p_wake_partial_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && asleep && cmd_op == OP_WAKE && !cmd_whole) |=> (asleep && cmd_abort));
  // R9: reset without enable takes no effect
  p_reset_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !asleep && cmd_op == OP_SWRST && !rst_enable) |=>
    (!cmd_accept && $stable(erase_paused) && $stable(prog_paused)));
  // R3: an abort never starts an operation
  p_abort_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |-> !$rose(busy));
endmodule

// File: tb/tb_flash_busy_ctl.sv
module tb_flash_busy_ctl;
  localparam int PROG_CYC = 20, ER_S_CYC = 40, ER_M_CYC = 60, ER_L_CYC = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_whole = 1'b0, cmd_confirm = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [4:0] cmd_sector = '0;
  logic rst_enable = 1'b0, op_fail = 1'b0;
  logic busy, err_flag, prog_paused, erase_paused, asleep;
  logic cmd_accept, cmd_abort, wel_clear;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  flash_busy_ctl #(.SEC_W(5), .PROG_CYC(PROG_CYC), .ER_S_CYC(ER_S_CYC),
                   .ER_M_CYC(ER_M_CYC), .ER_L_CYC(ER_L_CYC)) dut (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_whole, .cmd_confirm, .cmd_sector,
    .rst_enable, .op_fail, .busy, .err_flag, .prog_paused, .erase_paused,
    .asleep, .cmd_accept, .cmd_abort, .wel_clear
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; op_fail = 1'b0; rst_enable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive at a negedge, return at the negedge after the sampling edge
  task automatic send(input logic [3:0] op, input int sec, input bit whole, input bit conf);
    cmd_valid = 1'b1; cmd_op = op; cmd_sector = 5'(sec);
    cmd_whole = whole; cmd_confirm = conf;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_whole = 1'b0; cmd_confirm = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_state();
    hw_reset();
    eq("R1 busy", busy, 0);
    eq("R1 err", err_flag, 0);
    eq("R1 prog_paused", prog_paused, 0);
    eq("R1 erase_paused", erase_paused, 0);
    eq("R1 asleep", asleep, 0);
  endtask

  task automatic t_lengths();
    int n;
    int durs[4] = '{PROG_CYC, ER_S_CYC, ER_M_CYC, ER_L_CYC};
    hw_reset();
    for (int i = 0; i < 4; i++) begin
      send(4'(i + 1), 1, 1, 0);
      eq("R2 accept", cmd_accept, 1);
      busy_len(n);
      eq("R2 busy length", n, durs[i]);
      eq("R2 wel_clear at end", wel_clear, 1);
      @(negedge clk);
    end
    send(4'd2, 1, 1, 0);
    send(4'd1, 2, 1, 0);
    eq("R2 busy program ignored accept", cmd_accept, 0);
    eq("R2 busy program ignored abort", cmd_abort, 0);
    busy_len(n);
    eq("R2 erase length unchanged", n + 1, ER_S_CYC);
  endtask

  task automatic t_partial();
    hw_reset();
    send(4'd1, 0, 0, 0);
    eq("R3 partial program abort", cmd_abort, 1);
    eq("R3 partial program not busy", busy, 0);
    send(4'd4, 0, 0, 0);
    eq("R3 partial erase abort", cmd_abort, 1);
    eq("R3 partial erase not busy", busy, 0);
  endtask

  task automatic t_pause();
    int n;
    hw_reset();
    send(4'd1, 3, 1, 0);
    repeat (4) @(negedge clk);
    send(4'd5, 0, 1, 0);
    eq("R4 pause drops busy", busy, 0);
    eq("R4 program paused", prog_paused, 1);
    send(4'd6, 0, 1, 0);
    eq("R5 resume accept", cmd_accept, 1);
    busy_len(n);
    eq("R4 total length", n + 5, PROG_CYC);
    eq("R5 program flag cleared", prog_paused, 0);
    // nested pause
    send(4'd2, 3, 1, 0);
    repeat (2) @(negedge clk);
    send(4'd5, 0, 1, 0);
    eq("R4 erase paused", erase_paused, 1);
    send(4'd1, 5, 1, 0);
    eq("R6 other sector program runs", busy, 1);
    send(4'd5, 0, 1, 0);
    eq("R5 nested both paused", prog_paused + erase_paused, 2);
    send(4'd6, 0, 1, 0);
    eq("R5 program first", prog_paused, 0);
    eq("R5 erase still paused", erase_paused, 1);
    busy_len(n);
    eq("R5 nested program remainder", n, PROG_CYC - 1);
    send(4'd6, 0, 1, 0);
    busy_len(n);
    eq("R5 erase remainder", n + 3, ER_S_CYC);
    eq("R5 erase flag cleared", erase_paused, 0);
  endtask

  task automatic t_conflict();
    hw_reset();
    send(4'd3, 2, 1, 0);
    send(4'd5, 0, 1, 0);
    send(4'd1, 2, 1, 0);
    eq("R6 same sector abort", cmd_abort, 1);
    eq("R6 same sector wel_clear", wel_clear, 1);
    eq("R6 same sector idle", busy, 0);
    send(4'd2, 7, 1, 0);
    eq("R7 erase during pause abort", cmd_abort, 1);
    eq("R7 erase during pause wel_clear", wel_clear, 1);
    send(4'd1, 4, 1, 0);
    eq("R6 other sector accept", cmd_accept, 1);
    send(4'd5, 0, 1, 0);
    send(4'd1, 9, 1, 0);
    eq("R7 second program abort", cmd_abort, 1);
    eq("R7 second program idle", busy, 0);
  endtask

  task automatic t_error();
    int n;
    hw_reset();
    send(4'd1, 0, 1, 0);
    repeat (3) @(negedge clk);
    op_fail = 1'b1;
    @(negedge clk);
    op_fail = 1'b0;
    busy_len(n);
    eq("R8 error after failed program", err_flag, 1);
    send(4'd2, 0, 1, 0);
    eq("R8 error cleared at start", err_flag, 0);
    busy_len(n);
    eq("R8 clean erase no error", err_flag, 0);
  endtask

  task automatic t_swreset();
    hw_reset();
    send(4'd2, 6, 1, 0);
    send(4'd5, 0, 1, 0);
    rst_enable = 1'b0;
    send(4'd7, 0, 1, 1);
    eq("R9 disabled reset no accept", cmd_accept, 0);
    eq("R9 disabled reset keeps pause", erase_paused, 1);
    rst_enable = 1'b1;
    send(4'd7, 0, 1, 0);
    eq("R9 unconfirmed reset keeps pause", erase_paused, 1);
    send(4'd7, 0, 0, 1);
    eq("R9 partial reset keeps pause", erase_paused, 1);
    send(4'd7, 0, 1, 1);
    eq("R9 reset accept", cmd_accept, 1);
    eq("R9 reset drops pause", erase_paused, 0);
    send(4'd6, 0, 1, 0);
    eq("R9 nothing to resume", busy, 0);
    send(4'd1, 0, 1, 0);
    send(4'd7, 0, 1, 1);
    eq("R9 reset stops busy", busy, 0);
    rst_enable = 1'b0;
  endtask

  task automatic t_sleep();
    int n;
    hw_reset();
    send(4'd1, 0, 1, 0);
    send(4'd8, 0, 1, 0);
    eq("R10 sleep while busy ignored", asleep, 0);
    eq("R10 sleep while busy no accept", cmd_accept, 0);
    busy_len(n);
    send(4'd8, 0, 0, 0);
    eq("R10 partial sleep abort", cmd_abort, 1);
    eq("R10 partial sleep awake", asleep, 0);
    send(4'd8, 0, 1, 0);
    eq("R10 sleep entered", asleep, 1);
    send(4'd1, 0, 1, 0);
    eq("R11 program ignored asleep", busy + cmd_accept + cmd_abort, 0);
    rst_enable = 1'b1;
    send(4'd7, 0, 1, 1);
    eq("R11 reset ignored asleep", asleep, 1);
    rst_enable = 1'b0;
    send(4'd9, 0, 0, 0);
    eq("R12 partial wake abort", cmd_abort, 1);
    eq("R12 partial wake stays asleep", asleep, 1);
    send(4'd9, 0, 1, 0);
    eq("R12 wake accept", cmd_accept, 1);
    eq("R12 awake", asleep, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_lengths();
    t_partial();
    t_pause();
    t_conflict();
    t_error();
    t_swreset();
    t_sleep();
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule